// File: doc/BRIEF.md
# Headset Jack Event Classifier

This block sits behind the analog comparators of a headset-detection front end and turns their raw levels into clean events for a host. It filters three inputs: the mechanical jack switch, the electrical microphone detector and the button detector. Each one goes through a counter clocked by a 1 ms tick strobe, so the block runs from any system clock. Accepted switch events drive a small classification state. Accepted button events are decoded from a 5-bit thermometer comparator result into one of five held button bits.

While no plug is resolved, the block sits in a detection mode. In this mode a lowest-button press is taken as an accessory probe rather than a key. When the plug's insertion is accepted, a probe press that never saw a matching release marks the accessory as a three-pole headphone. Otherwise the accessory is a four-pole headset. Every kind of event also latches a cause bit into a write-one-to-clear status register. A set/clear enable mask gates those bits into one interrupt line.

Top module: `hs_jack_classifier`

## Requirements
- R1: Outside detection mode, an accepted button press sets exactly one bit of btn_state from btn_code. The mapping is 5'b00000 to bit 0, 5'b00001 to bit 1, 5'b00011 to bit 2, 5'b00111 to bit 3 and 5'b01111 to bit 4. The bit is held until a release is accepted.
- R2: A press whose btn_code is any other value changes no button bit and sets code_err. code_err stays set until reset.
- R3: After reset, and after every accepted removal, detect_mode is 1. In this mode a press with code 5'b00000 sets a hidden probe flag and sets no button bit.
- R4: In detection mode, a release accepted while btn_code is 5'b00000 clears the probe flag.
- R5: On an accepted insertion, hp_present becomes 1 if the probe flag is set. Otherwise hs_present becomes 1. detect_mode then drops to 0. hp_present and hs_present are never both 1.
- R6: An accepted removal clears hp_present, hs_present, btn_state and the probe flag, and sets detect_mode.
- R7: The switch filter looks for one event type at a time. look_for_ins is 1 after reset and toggles after each accepted switch event. A jack_sw level that equals the current state is ignored.
- R8: jack_sw and mic_det must hold a new level for INS_MS consecutive ticks, and btn_det for BTN_MS ticks, before the event is accepted. Any return to the old level restarts the count. The defaults are 256 and 16.
- R9: Accepted events set these int_status bits: bit 7 for a switch event, bit 6 for a mic level change, bit 5 for a press and bit 4 for a release. A 1 on int_ack clears the bit, but a new event in the same cycle wins.
- R10: A 1 on int_en_set sets the int_en bit and a 1 on int_en_clr clears it. Clear wins when both arrive in the same cycle. Bits 3:0 of int_en and int_status always read 0.
- R11: irq is 1 exactly when some int_status bit and the same int_en bit are both 1.
- R12: Any accepted release clears all bits of btn_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| jack_sw | input | 1 | Raw jack switch level, 1 = plug seen |
| mic_det | input | 1 | Raw electrical mic detector level |
| btn_det | input | 1 | Raw button detector level, 1 = pressed |
| btn_code | input | 5 | Button comparator thermometer result |
| int_en_set | input | 8 | Per-bit enable set strobes |
| int_en_clr | input | 8 | Per-bit enable clear strobes |
| int_ack | input | 8 | Per-bit write-one-to-clear strobes for status |
| irq | output | 1 | Masked interrupt request |
| int_status | output | 8 | Latched event causes |
| int_en | output | 8 | Interrupt enable mask |
| hp_present | output | 1 | Three-pole headphone plugged |
| hs_present | output | 1 | Four-pole headset plugged |
| btn_state | output | 5 | Held button, one-hot |
| code_err | output | 1 | Sticky invalid comparator code flag |
| detect_mode | output | 1 | Accessory-type detection mode |
| look_for_ins | output | 1 | Switch filter is waiting for insertion |
| mic_present | output | 1 | Filtered mic detector level |

## Verification
Some properties are checked by assertions on every cycle:
- btn_state stays one-hot or zero.
- code_err never falls.
- A bad code leaves the buttons untouched.
- hp_present and hs_present are exclusive.
- The filter counters stay inside their window and filter states move only on a tick.
- A status acknowledge or enable clear takes effect.

Other behaviour only the bench scenarios can show: the probe sequences that decide headphone versus headset, that a glitch shorter than the window is rejected, the exact cycle each event is accepted, and the decoding of each code. These are compared against a per-cycle behavioural model.

// File: rtl/hsjc_pkg.sv
package hsjc_pkg;
  localparam int NUM_BTN = 5;
  localparam int CODE_W  = 5;
  localparam int IDX_W   = $clog2(NUM_BTN);
  localparam int IRQ_W   = 8;
  localparam int IRQ_SW    = 7;
  localparam int IRQ_MIC   = 6;
  localparam int IRQ_PRESS = 5;
  localparam int IRQ_REL   = 4;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 8'hF0;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] idx;
  } btn_dec_t;

  // Thermometer result: k low ones selects button k.
  function automatic btn_dec_t therm_decode(input logic [CODE_W-1:0] code);
    btn_dec_t r;
    r.ok  = 1'b0;
    r.idx = '0;
    for (int k = 0; k < NUM_BTN; k++) begin
      if (code == CODE_W'((1 << k) - 1)) begin
        r.ok  = 1'b1;
        r.idx = IDX_W'(k);
      end
    end
    return r;
  endfunction

  function automatic logic [NUM_BTN-1:0] btn_onehot(input logic [IDX_W-1:0] idx);
    return NUM_BTN'(1) << idx;
  endfunction
endpackage

// File: rtl/hsjc_debounce.sv
module hsjc_debounce #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic state,
  output logic evt
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;
  logic          differ;

  assign differ = (din != state);
  assign evt    = tick && differ && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= 1'b0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (tick) begin
      if (evt) begin
        cnt   <= '0;
        state <= din;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LEN)) else $error("counter left window"); // R8
  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state)) else $error("state moved without tick"); // R8
endmodule

// File: rtl/hsjc_classify.sv
module hsjc_classify
  import hsjc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_evt,
  input  logic              rem_evt,
  input  logic              press_evt,
  input  logic              rel_evt,
  input  logic [CODE_W-1:0] code,
  output logic              hp_present,
  output logic              hs_present,
  output logic [NUM_BTN-1:0] btn_state,
  output logic              code_err,
  output logic              detect_mode
);
  logic     probe;
  btn_dec_t dec;

  assign dec = therm_decode(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe       <= 1'b0;
      hp_present  <= 1'b0;
      hs_present  <= 1'b0;
      btn_state   <= '0;
      code_err    <= 1'b0;
      detect_mode <= 1'b1;
    end else begin
      if (press_evt) begin
        if (!dec.ok)                                code_err  <= 1'b1;
        else if (detect_mode && dec.idx == '0)      probe     <= 1'b1;
        else                                        btn_state <= btn_onehot(dec.idx);
      end
      if (rel_evt) begin
        btn_state <= '0;
        if (detect_mode && code == '0) probe <= 1'b0;
      end
      if (ins_evt) begin
        hp_present  <= probe;
        hs_present  <= !probe;
        detect_mode <= 1'b0;
      end
      if (rem_evt) begin
        hp_present  <= 1'b0;
        hs_present  <= 1'b0;
        btn_state   <= '0;
        probe       <= 1'b0;
        detect_mode <= 1'b1;
      end
    end
  end

  AST_BTN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(btn_state)) else $error("two buttons held"); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err) else $error("error flag fell"); // R2
  AST_BAD_CODE_NO_BTN: assert property (@(posedge clk) disable iff (!rst_n)
    (press_evt && !dec.ok && !rem_evt) |=> $stable(btn_state)) else $error("bad code moved buttons"); // R2
  AST_PLUG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hp_present && hs_present)) else $error("both plug kinds"); // R5
  AST_DETECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    detect_mode |-> (!hp_present && !hs_present)) else $error("plug held in detection"); // R6
endmodule

// File: rtl/hsjc_irq.sv
module hsjc_irq
  import hsjc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] cause,
  input  logic [IRQ_W-1:0] en_set,
  input  logic [IRQ_W-1:0] en_clr,
  input  logic [IRQ_W-1:0] ack,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] en,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      en     <= '0;
    end else begin
      status <= ((status & ~ack) | cause) & IRQ_IMPL;
      en     <= (en | en_set) & ~en_clr & IRQ_IMPL;
    end
  end

  assign irq = |(status & en);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[IRQ_SW] && !cause[IRQ_SW]) |=> !status[IRQ_SW]) else $error("ack ignored"); // R9
  AST_CAUSE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    cause[IRQ_PRESS] |=> status[IRQ_PRESS]) else $error("cause lost"); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr[IRQ_SW] |=> !en[IRQ_SW]) else $error("enable clear lost"); // R10
endmodule

// File: rtl/hs_jack_classifier.sv
module hs_jack_classifier
  import hsjc_pkg::*;
#(
  parameter int INS_MS = 256,
  parameter int BTN_MS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1ms,
  input  logic        jack_sw,
  input  logic        mic_det,
  input  logic        btn_det,
  input  logic [4:0]  btn_code,
  input  logic [7:0]  int_en_set,
  input  logic [7:0]  int_en_clr,
  input  logic [7:0]  int_ack,
  output logic        irq,
  output logic [7:0]  int_status,
  output logic [7:0]  int_en,
  output logic        hp_present,
  output logic        hs_present,
  output logic [4:0]  btn_state,
  output logic        code_err,
  output logic        detect_mode,
  output logic        look_for_ins,
  output logic        mic_present
);
  logic plugged, sw_evt, mic_evt, btn_lvl, btn_evt;
  logic ins_evt, rem_evt, press_evt, rel_evt;
  logic [IRQ_W-1:0] cause;

  hsjc_debounce #(.LEN(INS_MS)) u_sw (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .din(jack_sw),
    .state(plugged), .evt(sw_evt));
  hsjc_debounce #(.LEN(INS_MS)) u_mic (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .din(mic_det),
    .state(mic_present), .evt(mic_evt));
  hsjc_debounce #(.LEN(BTN_MS)) u_btn (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .din(btn_det),
    .state(btn_lvl), .evt(btn_evt));

  // Named events, visible to assertions.
  assign ins_evt      = sw_evt && !plugged;
  assign rem_evt      = sw_evt && plugged;
  assign press_evt    = btn_evt && !btn_lvl;
  assign rel_evt      = btn_evt && btn_lvl;
  assign look_for_ins = !plugged;

  always_comb begin
    cause            = '0;
    cause[IRQ_SW]    = sw_evt;
    cause[IRQ_MIC]   = mic_evt;
    cause[IRQ_PRESS] = press_evt;
    cause[IRQ_REL]   = rel_evt;
  end

  hsjc_classify u_cls (
    .clk(clk), .rst_n(rst_n), .ins_evt(ins_evt), .rem_evt(rem_evt),
    .press_evt(press_evt), .rel_evt(rel_evt), .code(btn_code),
    .hp_present(hp_present), .hs_present(hs_present), .btn_state(btn_state),
    .code_err(code_err), .detect_mode(detect_mode));

  hsjc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .cause(cause), .en_set(int_en_set),
    .en_clr(int_en_clr), .ack(int_ack), .status(int_status),
    .en(int_en), .irq(irq));

  AST_SWITCH_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |=> (look_for_ins != $past(look_for_ins))) else $error("switch did not flip"); // R7
  AST_INS_LEAVES_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> !detect_mode) else $error("still detecting"); // R5
  AST_REL_CLEARS_BTN: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> (btn_state == '0)) else $error("button survived release"); // R12
endmodule

// File: tb/sim_hs_jack_classifier.sv
module sim_hs_jack_classifier;
  localparam int INS = 256;
  localparam int BTN = 16;

  logic clk = 0, rst_n = 0, tick = 0;
  logic jack_sw = 0, mic_det = 0, btn_det = 0;
  logic [4:0] btn_code = 0;
  logic [7:0] en_set = 0, en_clr = 0, ack = 0;
  logic irq, hp, hs, err, det, lfi, micp;
  logic [7:0] st, en;
  logic [4:0] btns;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hs_jack_classifier u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .jack_sw(jack_sw), .mic_det(mic_det),
    .btn_det(btn_det), .btn_code(btn_code), .int_en_set(en_set), .int_en_clr(en_clr),
    .int_ack(ack), .irq(irq), .int_status(st), .int_en(en), .hp_present(hp),
    .hs_present(hs), .btn_state(btns), .code_err(err), .detect_mode(det),
    .look_for_ins(lfi), .mic_present(micp));

  // ---- behavioural reference ----
  int m_lvl[3], m_cnt[3];
  bit m_probe, m_hp, m_hs, m_err, m_det;
  int m_btn;
  int m_st, m_en;

  function automatic int code_to_btn(input logic [4:0] c);
    case (c)
      5'b00000: return 0;
      5'b00001: return 1;
      5'b00011: return 2;
      5'b00111: return 3;
      5'b01111: return 4;
      default:  return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) begin m_lvl[i] = 0; m_cnt[i] = 0; end
      m_probe = 0; m_hp = 0; m_hs = 0; m_err = 0; m_det = 1; m_btn = 0;
      m_st = 0; m_en = 0;
    end else begin
      int din[3];
      int len[3];
      bit hit[3];
      bit old_probe, old_det;
      int b, cause;
      din = '{int'(jack_sw), int'(mic_det), int'(btn_det)};
      len = '{INS, INS, BTN};
      for (int i = 0; i < 3; i++) begin
        hit[i] = 0;
        if (din[i] == m_lvl[i]) m_cnt[i] = 0;
        else if (tick) begin
          if (m_cnt[i] + 1 == len[i]) begin hit[i] = 1; m_cnt[i] = 0; m_lvl[i] = din[i]; end
          else m_cnt[i]++;
        end
      end
      old_probe = m_probe; old_det = m_det;
      b = code_to_btn(btn_code);
      if (hit[2] && m_lvl[2] == 1) begin
        if (b < 0) m_err = 1;
        else if (old_det && b == 0) m_probe = 1;
        else m_btn = 1 << b;
      end
      if (hit[2] && m_lvl[2] == 0) begin
        m_btn = 0;
        if (old_det && btn_code == 0) m_probe = 0;
      end
      if (hit[0] && m_lvl[0] == 1) begin m_hp = old_probe; m_hs = !old_probe; m_det = 0; end
      if (hit[0] && m_lvl[0] == 0) begin m_hp = 0; m_hs = 0; m_btn = 0; m_probe = 0; m_det = 1; end
      cause = (hit[0] ? 128 : 0) + (hit[1] ? 64 : 0)
            + ((hit[2] && m_lvl[2] == 1) ? 32 : 0) + ((hit[2] && m_lvl[2] == 0) ? 16 : 0);
      m_st = ((m_st & ~int'(ack)) | cause) & 'hF0;
      m_en = ((m_en | int'(en_set)) & ~int'(en_clr)) & 'hF0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and tick generation
  int tdiv = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 hp_present", hp, m_hp);
      check("R5 hs_present", hs, m_hs);
      check("R1 btn_state", btns, m_btn);
      check("R2 code_err", err, m_err);
      check("R3 detect_mode", det, m_det);
      check("R7 look_for_ins", lfi, !m_lvl[0]);
      check("R8 mic_present", micp, m_lvl[1]);
      check("R9 int_status", st, m_st);
      check("R10 int_en", en, m_en);
      check("R11 irq", irq, (m_st & m_en) != 0);
    end
    tdiv <= tdiv + 1;
    tick <= (tdiv % 2 == 1);
  end

  task automatic waitms(input int n);
    repeat (n * 2) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [7:0] v);
    en_set = v; @(negedge clk); en_set = 0;
  endtask
  task automatic pulse_clr(input logic [7:0] v);
    en_clr = v; @(negedge clk); en_clr = 0;
  endtask
  task automatic pulse_ack(input logic [7:0] v);
    ack = v; @(negedge clk); ack = 0;
  endtask
  task automatic press(input logic [4:0] c);
    btn_code = c; btn_det = 1; waitms(BTN + 3);
  endtask
  task automatic release_btn(input logic [4:0] c);
    btn_code = c; btn_det = 0; waitms(BTN + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R3 reset detect", det, 1);
    check("R7 reset look_for_ins", lfi, 1);
    check("R11 reset irq", irq, 0);
    check("R1 reset buttons", btns, 0);

    // enable mask: low bits never stick, clear wins
    pulse_set(8'hFF);
    @(negedge clk);
    check("R10 enable set", en, 8'hF0);
    en_set = 8'h40; en_clr = 8'h40; @(negedge clk); en_set = 0; en_clr = 0;
    @(negedge clk);
    check("R10 clear wins", en, 8'hB0);

    // short glitch rejected
    jack_sw = 1; waitms(INS / 2); jack_sw = 0; waitms(10);
    check("R8 glitch ignored", st[7], 0);
    check("R8 glitch keeps look_for_ins", lfi, 1);

    // headset insertion
    jack_sw = 1; waitms(INS + 3);
    check("R5 headset", {hp, hs}, 2'b01);
    check("R7 now looking for removal", lfi, 0);
    check("R9 switch cause", st[7], 1);
    check("R11 irq raised", irq, 1);
    pulse_ack(8'h80);
    @(negedge clk);
    check("R9 ack clears", st[7], 0);
    check("R11 irq drops", irq, 0);

    // button decode for every valid code
    for (int k = 0; k < 5; k++) begin
      logic [4:0] c;
      c = 5'((1 << k) - 1);
      press(c);
      check("R1 button decode", btns, 1 << k);
      release_btn(c);
      check("R12 release clears", btns, 0);
    end
    check("R9 press/release causes", st[5:4], 2'b11);
    pulse_ack(8'h30);

    // short button bounce
    btn_code = 5'b00011; btn_det = 1; waitms(BTN / 2); btn_det = 0; waitms(4);
    check("R8 button bounce ignored", btns, 0);

    // invalid code
    press(5'b00101);
    check("R2 bad code no button", btns, 0);
    check("R2 error set", err, 1);
    release_btn(5'b00101);
    check("R2 error sticky", err, 1);

    // mic detector change
    mic_det = 1; waitms(INS + 3);
    check("R9 mic cause", st[6], 1);

    // removal
    jack_sw = 0; waitms(INS + 3);
    check("R6 removal clears", {hp, hs}, 2'b00);
    check("R6 detect again", det, 1);
    check("R7 looking for insertion", lfi, 1);

    // probe press held through insertion -> headphone
    press(5'b00000);
    check("R3 probe not a button", btns, 0);
    jack_sw = 1; waitms(INS + 3);
    check("R5 headphone", {hp, hs}, 2'b10);
    release_btn(5'b00000);
    check("R12 release outside detect", btns, 0);
    press(5'b00000);
    check("R1 button 0 outside detect", btns, 5'b00001);
    release_btn(5'b00000);
    jack_sw = 0; waitms(INS + 3);
    check("R6 headphone removed", {hp, hs}, 2'b00);

    // probe pressed and released -> headset
    press(5'b00000);
    release_btn(5'b00000);
    jack_sw = 1; waitms(INS + 3);
    check("R4 probe cleared gives headset", {hp, hs}, 2'b01);

    // masked cause does not interrupt
    pulse_ack(8'hF0);
    pulse_clr(8'hF0);
    jack_sw = 0; waitms(INS + 3);
    check("R11 masked cause", {st[7], irq}, 2'b10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule